// File: doc/BRIEF.md
# NVRAM Parameter-Area Checksum Engine

This block computes the 16-bit checksum that guards a firmware parameter area kept in a byte-addressed non-volatile memory. A single-cycle start pulse supplies a base address and a byte count. The engine then fetches the range one byte at a time through a request/valid read port. It pairs consecutive bytes into 16-bit words, with the byte at the lower address as the upper half. Each word is folded into a running checksum by a nibble-mixing update.

When the range ends on an unpaired byte, that byte becomes the upper half of a final word whose lower half is zero. Once every byte is folded, the engine writes the checksum back to a fixed offset through a byte write port, upper byte first. It then drops busy and raises done. A typical use is to recompute the checksum after firmware has changed the area, then store it at the offset the consumer checks at boot.

Top module: `nvsum_engine`

## Requirements
- R1: After synchronous reset, busy, done, rd_req and wr_en are all 0.
- R2: A start pulse seen while busy is 0 sets busy in the next cycle. The engine then reads addresses base, base+1, … base+count-1 in increasing order. It issues no new rd_req before the rd_valid that answers the previous one, and rd_req never stays high for two cycles in a row.
- R3: The checksum is seeded with 0xFFFF at each accepted start. A byte count of zero performs no reads and stores 0xFFFF.
- R4: Bytes are paired big-endian: word = {byte[a], byte[a+1]}. For each word w and previous value p, let d = p^w, n1 = d[3:0] and n2 = d[7:4]^n1. The new value is (p>>8) ^ (n1<<3) ^ (n1<<8) ^ n2 ^ (n2<<7) ^ (n2<<12), computed in 16 bits.
- R5: For an odd byte count, the last byte b is folded as the word {b, 8'h00}.
- R6: After the last read, the engine makes exactly two writes in consecutive cycles. The upper byte of the checksum goes to RESULT_OFS (default 0xFC), then the lower byte to RESULT_OFS+1.
- R7: A start pulse while busy is 1 has no effect. Neither the range being read nor the stored result changes.
- R8: busy falls and done rises in the cycle after the last write. done then holds until the next accepted start clears it, and busy and done are never high together.
- R9: The stored checksum does not depend on the read latency. Any number of cycles from rd_req to rd_valid gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to checksum a range |
| base_addr | input | AW | First byte address of the range |
| byte_count | input | CW | Number of bytes in the range |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | AW | Byte address of the read request |
| rd_valid | input | 1 | Read data is present on rd_data |
| rd_data | input | 8 | Byte returned by memory |
| wr_en | output | 1 | Byte write strobe for the result |
| wr_addr | output | AW | Write address |
| wr_data | output | 8 | Write byte |
| busy | output | 1 | A checksum run is in progress |
| done | output | 1 | The last run has finished and its result is stored |

## Verification
Directed tasks cover several distinct ranges:
- an empty range, which must store 0xFFFF; a design that forgot the seed or issued a stray read would store something else;
- even and odd lengths, where getting the byte order backwards or padding on the wrong side changes the stored value;
- the full 0xF8-byte area;
- slow and fast memory responses, which catch a design that overlaps requests or samples data before rd_valid.

A second start pulse fired mid-run shows whether the engine restarts or changes its range, which would alter the read count or the result. The bench also checks that done holds between runs and clears on the next start.

// File: rtl/nvsum_pkg.sv
package nvsum_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_WHI   = 3'd2,
    ST_WLO   = 3'd3,
    ST_FIN   = 3'd4
  } nvsum_state_e;

  localparam logic [15:0] SUM_SEED = 16'hFFFF;

  // One word step of the nibble-mixing checksum.
  function automatic logic [15:0] sum_step(input logic [15:0] prev,
                                           input logic [15:0] word);
    logic [15:0] acc;
    logic [15:0] mix;
    logic [15:0] n1;
    logic [15:0] n2;
    acc = prev >> 8;
    mix = prev ^ word;
    n1  = {12'h000, mix[3:0]};
    n2  = {12'h000, mix[7:4] ^ mix[3:0]};
    acc = acc ^ (n1 << 3) ^ (n1 << 8);
    acc = acc ^ n2 ^ (n2 << 7) ^ (n2 << 12);
    return acc;
  endfunction

endpackage

// File: rtl/nvsum_pair.sv
module nvsum_pair (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  input  logic        byte_last,
  output logic        word_vld,
  output logic [15:0] word
);
  logic       odd_q;
  logic [7:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      odd_q <= 1'b0;
      hi_q  <= 8'h00;
    end else if (byte_vld) begin
      odd_q <= ~odd_q;
      hi_q  <= byte_in;
    end
  end

  assign word_vld = byte_vld && (odd_q || byte_last);
  assign word     = odd_q ? {hi_q, byte_in} : {byte_in, 8'h00};

endmodule

// File: rtl/nvsum_fold.sv
module nvsum_fold
  import nvsum_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        word_vld,
  input  logic [15:0] word,
  output logic [15:0] sum
);
  logic [15:0] sum_q;

  always_ff @(posedge clk) begin
    if (rst || clear) sum_q <= SUM_SEED;
    else if (word_vld) sum_q <= sum_step(sum_q, word);
  end

  assign sum = sum_q;

  // R3: a clear pulse reseeds the accumulator
  a_r3_clear_seed: assert property (@(posedge clk) disable iff (rst)
    clear |=> (sum == 16'hFFFF));

endmodule

// File: rtl/nvsum_ctrl.sv
module nvsum_ctrl
  import nvsum_pkg::*;
#(
  parameter int AW         = 8,
  parameter int CW         = 9,
  parameter int RESULT_OFS = 'hFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] byte_count,
  input  logic          rd_valid,
  input  logic [15:0]   sum,
  output logic          clear,
  output logic          byte_vld,
  output logic          byte_last,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic          done
);
  localparam logic [AW-1:0] OFS_HI = AW'(RESULT_OFS);
  localparam logic [AW-1:0] OFS_LO = AW'(RESULT_OFS + 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  nvsum_state_e  state_q;
  logic [AW-1:0] next_q;
  logic [CW-1:0] left_q;
  logic          rd_req_q, wr_en_q, busy_q, done_q;
  logic [AW-1:0] rd_addr_q, wr_addr_q;
  logic [7:0]    wr_data_q;
  logic          accept;

  assign accept    = (state_q == ST_IDLE) && start;
  assign clear     = accept;
  assign byte_vld  = (state_q == ST_WAIT) && rd_valid;
  assign byte_last = (left_q == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      next_q    <= '0;
      left_q    <= '0;
      rd_req_q  <= 1'b0;
      rd_addr_q <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= 8'h00;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rd_req_q <= 1'b0;
      wr_en_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            left_q <= byte_count;
            if (byte_count == '0) begin
              state_q <= ST_WHI;
            end else begin
              rd_req_q  <= 1'b1;
              rd_addr_q <= base_addr;
              next_q    <= base_addr + 1'b1;
              state_q   <= ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (rd_valid) begin
            left_q <= left_q - ONE;
            if (left_q == ONE) begin
              state_q <= ST_WHI;
            end else begin
              rd_req_q  <= 1'b1;
              rd_addr_q <= next_q;
              next_q    <= next_q + 1'b1;
            end
          end
        end
        ST_WHI: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= OFS_HI;
          wr_data_q <= sum[15:8];
          state_q   <= ST_WLO;
        end
        ST_WLO: begin
          wr_en_q   <= 1'b1;
          wr_addr_q <= OFS_LO;
          wr_data_q <= sum[7:0];
          state_q   <= ST_FIN;
        end
        ST_FIN: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_req  = rd_req_q;
  assign rd_addr = rd_addr_q;
  assign wr_en   = wr_en_q;
  assign wr_addr = wr_addr_q;
  assign wr_data = wr_data_q;
  assign busy    = busy_q;
  assign done    = done_q;

  // R2: one request in flight, never back-to-back
  a_r2_single_req: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  // R6: upper byte write is followed at once by the lower byte write
  a_r6_wr_pair: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == OFS_HI) |=> (wr_en && wr_addr == OFS_LO));

  // R8: busy and done are exclusive
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7: a start while busy never enlarges the remaining count
  a_r7_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (left_q <= $past(left_q)));

endmodule

// File: rtl/nvsum_engine.sv
module nvsum_engine #(
  parameter int AW         = 8,
  parameter int CW         = 9,
  parameter int RESULT_OFS = 'hFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base_addr,
  input  logic [CW-1:0] byte_count,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          busy,
  output logic          done
);
  logic        clear;
  logic        byte_vld;
  logic        byte_last;
  logic        word_vld;
  logic [15:0] word;
  logic [15:0] sum;

  nvsum_ctrl #(.AW(AW), .CW(CW), .RESULT_OFS(RESULT_OFS)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .byte_count(byte_count), .rd_valid(rd_valid), .sum(sum),
    .clear(clear), .byte_vld(byte_vld), .byte_last(byte_last),
    .rd_req(rd_req), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done)
  );

  nvsum_pair u_pair (
    .clk(clk), .rst(rst), .clear(clear), .byte_vld(byte_vld),
    .byte_in(rd_data), .byte_last(byte_last),
    .word_vld(word_vld), .word(word)
  );

  nvsum_fold u_fold (
    .clk(clk), .rst(rst), .clear(clear), .word_vld(word_vld),
    .word(word), .sum(sum)
  );

endmodule

// File: tb/nvsum_engine_test.sv
module nvsum_engine_test;
  localparam int AW = 8;
  localparam int CW = 9;
  localparam int OFS = 'hFC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [7:0]    rd_data = 8'h00;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data;
  logic          busy;
  logic          done;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  int lat = 1;

  logic [7:0] mem [0:255];
  int rd_log [0:511];
  int wr_log [0:15];
  int n_rd = 0;
  int n_wr = 0;
  logic       pend = 1'b0;
  int         pcnt = 0;
  logic [7:0] paddr = 8'h00;

  always #5 clk = ~clk;

  nvsum_engine #(.AW(AW), .CW(CW), .RESULT_OFS(OFS)) uut (
    .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
    .byte_count(byte_count), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(done)
  );

  // synchronous memory model with adjustable read latency
  always @(posedge clk) begin
    cycles <= cycles + 1;
    rd_valid <= 1'b0;
    if (rd_req) begin
      pend  <= 1'b1;
      pcnt  <= lat;
      paddr <= rd_addr;
      if (n_rd < 512) rd_log[n_rd] = int'(rd_addr);
      n_rd = n_rd + 1;
    end else if (pend) begin
      if (pcnt <= 1) begin
        rd_valid <= 1'b1;
        rd_data  <= mem[paddr];
        pend     <= 1'b0;
      end else begin
        pcnt <= pcnt - 1;
      end
    end
    if (wr_en) begin
      mem[wr_addr] <= wr_data;
      if (n_wr < 16) wr_log[n_wr] = int'(wr_addr);
      n_wr = n_wr + 1;
    end
  end

  function automatic logic [15:0] ref_step(logic [15:0] p, logic [15:0] w);
    logic [15:0] d, a, n1, n2;
    d  = p ^ w;
    n1 = {12'h0, d[3:0]};
    n2 = {12'h0, d[7:4] ^ d[3:0]};
    a  = (p >> 8) ^ (n1 << 3) ^ (n1 << 8) ^ n2 ^ (n2 << 7) ^ (n2 << 12);
    return a;
  endfunction

  function automatic logic [15:0] ref_sum(int b, int n);
    logic [15:0] s;
    int i;
    s = 16'hFFFF;
    i = 0;
    while (i + 1 < n) begin
      s = ref_step(s, {mem[(b + i) % 256], mem[(b + i + 1) % 256]});
      i = i + 2;
    end
    if (i < n) s = ref_step(s, {mem[(b + i) % 256], 8'h00});
    return s;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fail);
    $finish;
  endtask

  task automatic fill_random();
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
  endtask

  task automatic pulse_start(input int b, input int n);
    @(negedge clk);
    base_addr  = AW'(b);
    byte_count = CW'(n);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    check(done, "R8", "done within limit", int'(done), 1);
  endtask

  // full run plus checks of order, writes and value
  task automatic run_range(input int b, input int n, input int l,
                           input string req);
    logic [15:0] exp;
    logic ord_ok;
    lat  = l;
    exp  = ref_sum(b, n);
    n_rd = 0;
    n_wr = 0;
    pulse_start(b, n);
    check(busy == 1'b1 && done == 1'b0, "R2", "busy after start",
          int'(busy), 1);
    wait_done();
    check(n_rd == n, "R2", "read count", n_rd, n);
    ord_ok = 1'b1;
    for (int i = 0; i < n && i < 512; i++)
      if (rd_log[i] != (b + i) % 256) ord_ok = 1'b0;
    check(ord_ok, "R2", "read order", int'(ord_ok), 1);
    check(n_wr == 2 && wr_log[0] == OFS && wr_log[1] == OFS + 1, "R6",
          "write addresses", wr_log[0], OFS);
    check({mem[OFS], mem[OFS + 1]} == exp, req, "stored checksum",
          int'({mem[OFS], mem[OFS + 1]}), int'(exp));
  endtask

  task automatic t_reset();
    check(!busy && !done && !rd_req && !wr_en, "R1", "reset outputs",
          int'({busy, done, rd_req, wr_en}), 0);
  endtask

  task automatic t_zero();
    fill_random();
    run_range(0, 0, 1, "R3");
    check(n_rd == 0, "R3", "no reads for empty range", n_rd, 0);
    check({mem[OFS], mem[OFS + 1]} == 16'hFFFF, "R3", "empty seed",
          int'({mem[OFS], mem[OFS + 1]}), 'hFFFF);
  endtask

  task automatic t_even();
    fill_random();
    run_range(0, 'hF8, 1, "R4");
    fill_random();
    run_range(16, 2, 1, "R4");
    fill_random();
    run_range(3, 100, 2, "R4");
  endtask

  task automatic t_odd();
    fill_random();
    run_range(0, 1, 1, "R5");
    fill_random();
    run_range(7, 77, 1, "R5");
    fill_random();
    run_range(0, 'hF7, 3, "R5");
  endtask

  task automatic t_latency();
    logic [15:0] r1;
    fill_random();
    run_range(5, 41, 1, "R9");
    r1 = {mem[OFS], mem[OFS + 1]};
    run_range(5, 41, 6, "R9");
    check({mem[OFS], mem[OFS + 1]} == r1, "R9", "latency independence",
          int'({mem[OFS], mem[OFS + 1]}), int'(r1));
  endtask

  task automatic t_busy_start();
    logic [15:0] exp;
    fill_random();
    lat  = 2;
    exp  = ref_sum(20, 30);
    n_rd = 0;
    n_wr = 0;
    pulse_start(20, 30);
    repeat (6) @(negedge clk);
    pulse_start(0, 3);
    wait_done();
    check(n_rd == 30, "R7", "reads with start while busy", n_rd, 30);
    check({mem[OFS], mem[OFS + 1]} == exp, "R7", "result unchanged",
          int'({mem[OFS], mem[OFS + 1]}), int'(exp));
  endtask

  task automatic t_done_hold();
    fill_random();
    run_range(0, 4, 1, "R4");
    repeat (5) @(negedge clk);
    check(done && !busy, "R8", "done holds", int'({done, busy}), 2);
    pulse_start(0, 4);
    check(!done && busy, "R8", "done cleared by start",
          int'({done, busy}), 1);
    wait_done();
  endtask

  initial begin
    while (cycles < 150000) @(negedge clk);
    check(1'b0, "WD", "watchdog expired", cycles, 0);
    finish_up();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_even();
    t_odd();
    t_latency();
    t_busy_start();
    t_done_hold();
    finish_up();
  end

endmodule